// File: doc/BRIEF.md
# UDP Receive Header Filter

This block sits on the receive side of an Ethernet MAC and watches the byte stream it delivers. It marks each byte with a valid, start-of-frame and end-of-frame flag. The block reads the Ethernet, IPv4 and UDP headers at fixed byte positions. It then decides whether the frame belongs to the local UDP endpoint. For an accepted frame it passes on only the UDP payload, with first/last markers of its own. The payload size comes from the UDP length field, so Ethernet padding never leaks out.

The local MAC address, IPv4 address and listening port are static configuration inputs. A small table of UDP destination ports, each with an enable bit, lets service traffic be rejected even when it would otherwise match. Name-service chatter on ports 137 and 5355 is the obvious case, and both are loaded at reset. Two saturating-free event counters give the number of accepted and rejected frames for debug.

Top module: `udp_rx_filter`

## Requirements
- R1: After reset the outputs `outValid`, `outFirst` and `outLast` are low, both frame counters read zero, drop-table entry 0 holds port 137 and entry 1 holds port 5355 (both enabled), and entries 2 and 3 are disabled.
- R2: A frame is accepted when all of these hold at their byte position from the start of frame: bytes 0-5 equal `cfgMac` (byte 0 = bits 47:40); bytes 12-13 equal 0x08,0x00; byte 14 equals 0x45; byte 20 has bits 5:0 clear and byte 21 is 0x00 (no more-fragments flag, zero offset; the don't-fragment bit 6 is allowed); byte 23 equals 17; bytes 30-33 equal `cfgIp` (byte 30 = bits 31:24); the big-endian port in bytes 36-37 equals `cfgPort` and hits no enabled drop-table entry; the big-endian UDP length in bytes 38-39 is at least 8. Each accepted frame adds one to `acceptCount`.
- R3: A frame that fails any condition of R2 produces no output and adds one to `dropCount`. The decision is taken on byte 39.
- R4: A drop-table entry is rewritten when `dropWe` is high on a clock edge: `dropSel` picks the entry, and `dropPortIn` and `dropEnIn` give its port and enable. A disabled entry never rejects a frame.
- R5: An accepted frame emits the bytes from offset 42 onward, one output byte per input byte, one cycle after the input byte. `outFirst` marks the first emitted byte and `outLast` the last.
- R6: The number of emitted bytes is the UDP length minus 8. A length of exactly 8 is accepted with no output, and a length below 8 is rejected.
- R7: Input bytes after the payload count is used up (padding) produce no output until the next start-of-frame.
- R8: A frame whose end-of-frame comes before byte 39 produces no output, leaves `acceptCount` unchanged and adds one to `dropCount`.
- R9: Header values are compared only at their own offsets. A valid header image placed inside the payload of a rejected frame never causes an accept or any output.
- R10: A start-of-frame byte always restarts parsing at offset 0, even inside an unfinished frame. The abandoned frame changes neither counter.
- R11: If end-of-frame arrives while payload is still owed, that byte is emitted with `outLast` set and output stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte qualifier |
| inSof | input | 1 | Input byte is frame offset 0 |
| inEof | input | 1 | Input byte is the last of the frame |
| inData | input | 8 | Input byte |
| cfgMac | input | 48 | Local MAC address |
| cfgIp | input | 32 | Local IPv4 address |
| cfgPort | input | 16 | Listening UDP destination port |
| dropWe | input | 1 | Drop-table write strobe |
| dropSel | input | 2 | Drop-table entry index |
| dropPortIn | input | 16 | Port written into the entry |
| dropEnIn | input | 1 | Enable written into the entry |
| outValid | output | 1 | Payload byte valid |
| outFirst | output | 1 | First payload byte |
| outLast | output | 1 | Last payload byte |
| outData | output | 8 | Payload byte |
| acceptCount | output | 16 | Accepted-frame count |
| dropCount | output | 16 | Rejected-frame count |

## Verification
The bench sends a good frame with trailing padding. A filter that trusted end-of-frame instead of the UDP length would emit the padding bytes. It then breaks one header field at a time, including a fragment flag with the don't-fragment bit kept set, and lengths of 7 and 8. An off-by-one offset or a missing field check would show up there as a stray accept. It also drives the drop table through its default entries, a disabled entry and a newly written one. Frames are cut off early, cut off mid-payload, restarted by a fresh start-of-frame, or given a valid header copy inside their payload. A parser that matched by pattern instead of by position would accept that last frame, and a count that was not reset on start-of-frame would mis-frame the next frame.

// File: rtl/udp_filt_pkg.sv
package udp_filt_pkg;
  localparam int IDX_W = 6;
  localparam int LEN_W = 16;

  // header byte offsets from frame start
  localparam int OFF_MAC0   = 0;
  localparam int OFF_ETH_HI = 12;
  localparam int OFF_ETH_LO = 13;
  localparam int OFF_VERIHL = 14;
  localparam int OFF_FLG_HI = 20;
  localparam int OFF_FLG_LO = 21;
  localparam int OFF_PROTO  = 23;
  localparam int OFF_DIP0   = 30;
  localparam int OFF_DPORT  = 36;
  localparam int OFF_ULEN   = 38;
  localparam int OFF_DECIDE = 39;
  localparam int OFF_PAY    = 42;
  localparam int UDP_HDR    = 8;

  typedef struct packed {
    logic             first;    // byte carries start of frame
    logic             check;    // byte belongs to the header window
    logic [IDX_W-1:0] idx;      // offset of the current byte
    logic             emit;     // forward current byte as payload
    logic             incAcc;   // frame accepted this cycle
    logic             incDrop;  // frame rejected this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/udp_filt_dp.sv
module udp_filt_dp
  import udp_filt_pkg::*;
#(
  parameter int NUM_DROP = 4,
  parameter int CNT_W    = 16,
  localparam int SEL_W   = (NUM_DROP > 1) ? $clog2(NUM_DROP) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inData,
  input  ctrlStrobe_t      strb,
  input  logic [47:0]      cfgMac,
  input  logic [31:0]      cfgIp,
  input  logic [15:0]      cfgPort,
  input  logic             dropWe,
  input  logic [SEL_W-1:0] dropSel,
  input  logic [15:0]      dropPortIn,
  input  logic             dropEnIn,
  output logic             hdrPass,
  output logic [LEN_W-1:0] payLen,
  output logic [7:0]       outData,
  output logic [CNT_W-1:0] acceptCount,
  output logic [CNT_W-1:0] dropCount
);
  logic [15:0]    tblPort [NUM_DROP];
  logic [NUM_DROP-1:0] tblEn;
  logic [NUM_DROP-1:0] tblHit;

  // programmable drop table, two service ports preloaded
  for (genvar g = 0; g < NUM_DROP; g++) begin : g_tbl
    localparam logic [15:0] RST_PORT = (g == 0) ? 16'd137 : (g == 1) ? 16'd5355 : 16'd0;
    localparam logic        RST_EN   = (g < 2);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tblPort[g] <= RST_PORT;
        tblEn[g]   <= RST_EN;
      end else if (dropWe && (int'(dropSel) == g)) begin
        tblPort[g] <= dropPortIn;
        tblEn[g]   <= dropEnIn;
      end
    end
  end

  // expected byte at the current offset
  logic [7:0] macByte, ipByte;
  logic       byteOk;
  int         idxI;
  assign idxI = int'(strb.idx);

  always_comb begin
    macByte = '0;
    ipByte  = '0;
    for (int k = 0; k < 6; k++)
      if (idxI == OFF_MAC0 + k) macByte = cfgMac[8*(5-k) +: 8];
    for (int k = 0; k < 4; k++)
      if (idxI == OFF_DIP0 + k) ipByte = cfgIp[8*(3-k) +: 8];
  end

  always_comb begin
    byteOk = 1'b1;
    if (idxI >= OFF_MAC0 && idxI < OFF_MAC0 + 6)      byteOk = (inData == macByte);
    else if (idxI >= OFF_DIP0 && idxI < OFF_DIP0 + 4) byteOk = (inData == ipByte);
    else if (idxI == OFF_ETH_HI)                       byteOk = (inData == 8'h08);
    else if (idxI == OFF_ETH_LO)                       byteOk = (inData == 8'h00);
    else if (idxI == OFF_VERIHL)                       byteOk = (inData == 8'h45);
    else if (idxI == OFF_FLG_HI)                       byteOk = (inData[5:0] == 6'd0);
    else if (idxI == OFF_FLG_LO)                       byteOk = (inData == 8'h00);
    else if (idxI == OFF_PROTO)                        byteOk = (inData == 8'd17);
  end

  // running header verdict and captured fields
  logic        okAcc, okNow;
  logic [15:0] portReg;
  logic [7:0]  lenHi;
  logic [LEN_W-1:0] udpLen;

  assign okNow = (strb.first ? 1'b1 : okAcc) & byteOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      okAcc   <= 1'b0;
      portReg <= '0;
      lenHi   <= '0;
    end else if (strb.check) begin
      okAcc <= okNow;
      if (idxI == OFF_DPORT)     portReg[15:8] <= inData;
      if (idxI == OFF_DPORT + 1) portReg[7:0]  <= inData;
      if (idxI == OFF_ULEN)      lenHi         <= inData;
    end
  end

  for (genvar g = 0; g < NUM_DROP; g++) begin : g_hit
    assign tblHit[g] = tblEn[g] && (tblPort[g] == portReg);
  end

  assign udpLen  = {lenHi, inData};
  assign payLen  = udpLen - LEN_W'(UDP_HDR);
  assign hdrPass = okNow && (portReg == cfgPort) && (tblHit == '0)
                   && (udpLen >= LEN_W'(UDP_HDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData     <= '0;
      acceptCount <= '0;
      dropCount   <= '0;
    end else begin
      if (strb.emit)    outData     <= inData;
      if (strb.incAcc)  acceptCount <= acceptCount + 1'b1;
      if (strb.incDrop) dropCount   <= dropCount + 1'b1;
    end
  end
endmodule

// File: rtl/udp_filt_ctrl.sv
module udp_filt_ctrl
  import udp_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic             hdrPass,
  input  logic [LEN_W-1:0] payLen,
  output ctrlStrobe_t      strb,
  output logic             outValid,
  output logic             outFirst,
  output logic             outLast
);
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_TAIL, ST_PAY} state_t;

  state_t           state, nState;
  logic [IDX_W-1:0] idxReg, curIdx;
  logic [LEN_W-1:0] payCnt, nPayCnt;
  logic             firstPay, nFirstPay;
  logic             inHdr, decide;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  assign curIdx = inSof ? '0 : idxReg;
  assign inHdr  = inValid && (inSof || state == ST_HDR);
  assign decide = inHdr && (int'(curIdx) == OFF_DECIDE);

  always_comb begin
    strb.first   = inSof;
    strb.check   = inHdr;
    strb.idx     = curIdx;
    strb.emit    = inValid && !inSof && (state == ST_PAY);
    strb.incAcc  = decide && hdrPass;
    strb.incDrop = (decide && !hdrPass)
                || (inHdr && inEof && (int'(curIdx) < OFF_DECIDE));
  end

  always_comb begin
    nState    = state;
    nPayCnt   = payCnt;
    nFirstPay = firstPay;
    if (inValid) begin
      if (inSof) nState = ST_HDR;
      case (nState)
        ST_HDR: if (decide) begin
          nPayCnt   = payLen;
          nFirstPay = 1'b1;
          nState    = (hdrPass && payLen != '0) ? ST_TAIL : ST_IDLE;
        end
        ST_TAIL: if (int'(curIdx) == OFF_PAY - 1) nState = ST_PAY;
        ST_PAY: begin
          nPayCnt   = payCnt - 1'b1;
          nFirstPay = 1'b0;
          if (payCnt == LEN_W'(1)) nState = ST_IDLE;
        end
        default: ;
      endcase
      if (inEof) nState = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idxReg   <= '0;
      payCnt   <= '0;
      firstPay <= 1'b0;
      outValid <= 1'b0;
      outFirst <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      state    <= nState;
      payCnt   <= nPayCnt;
      firstPay <= nFirstPay;
      if (inValid) idxReg <= (curIdx == IDX_MAX) ? IDX_MAX : curIdx + 1'b1;
      outValid <= strb.emit;
      outFirst <= strb.emit && firstPay;
      outLast  <= strb.emit && (payCnt == LEN_W'(1) || inEof);
    end
  end
endmodule

// File: rtl/udp_rx_filter.sv
module udp_rx_filter
  import udp_filt_pkg::*;
#(
  parameter int NUM_DROP = 4,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [7:0]       inData,
  input  logic [47:0]      cfgMac,
  input  logic [31:0]      cfgIp,
  input  logic [15:0]      cfgPort,
  input  logic             dropWe,
  input  logic [1:0]       dropSel,
  input  logic [15:0]      dropPortIn,
  input  logic             dropEnIn,
  output logic             outValid,
  output logic             outFirst,
  output logic             outLast,
  output logic [7:0]       outData,
  output logic [CNT_W-1:0] acceptCount,
  output logic [CNT_W-1:0] dropCount
);
  ctrlStrobe_t      strb;
  logic             hdrPass;
  logic [LEN_W-1:0] payLen;

  udp_filt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .hdrPass(hdrPass), .payLen(payLen), .strb(strb),
    .outValid(outValid), .outFirst(outFirst), .outLast(outLast)
  );

  udp_filt_dp #(.NUM_DROP(NUM_DROP), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .strb(strb),
    .cfgMac(cfgMac), .cfgIp(cfgIp), .cfgPort(cfgPort),
    .dropWe(dropWe), .dropSel(dropSel[((NUM_DROP > 1) ? $clog2(NUM_DROP) : 1)-1:0]),
    .dropPortIn(dropPortIn), .dropEnIn(dropEnIn),
    .hdrPass(hdrPass), .payLen(payLen), .outData(outData),
    .acceptCount(acceptCount), .dropCount(dropCount)
  );
endmodule

// File: rtl/udp_rx_filter_chk.sv
module udp_rx_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic             outFirst,
  input logic             outLast,
  input logic [CNT_W-1:0] acceptCount,
  input logic [CNT_W-1:0] dropCount
);
  a_r5_first_has_valid: assert property (@(posedge clk) disable iff (!rstN)
    outFirst |-> outValid);

  a_r5_last_has_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  a_r5_out_needs_input: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  a_r11_stop_after_last: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> !outValid);

  a_r3_single_verdict: assert property (@(posedge clk) disable iff (!rstN)
    !((acceptCount != $past(acceptCount)) && (dropCount != $past(dropCount))));

  a_r2_accept_step: assert property (@(posedge clk) disable iff (!rstN)
    (acceptCount != $past(acceptCount)) |-> (acceptCount == $past(acceptCount) + 1'b1));

  a_r3_drop_step: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount != $past(dropCount)) |-> (dropCount == $past(dropCount) + 1'b1));
endmodule

bind udp_rx_filter udp_rx_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outFirst(outFirst), .outLast(outLast),
  .acceptCount(acceptCount), .dropCount(dropCount)
);

// File: tb/udp_rx_filter_tb.sv
module udp_rx_filter_tb;
  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0, inSof = 0, inEof = 0;
  logic [7:0] inData = 0;
  logic [47:0] cfgMac = 48'h02_11_22_33_44_55;
  logic [31:0] cfgIp  = 32'hC0_A8_0A_05;
  logic [15:0] cfgPort = 16'd5000;
  logic dropWe = 0, dropEnIn = 0;
  logic [1:0] dropSel = 0;
  logic [15:0] dropPortIn = 0;
  logic outValid, outFirst, outLast;
  logic [7:0] outData;
  logic [15:0] acceptCount, dropCount;

  int nRun = 0, nFail = 0;
  int expAcc = 0, expDrop = 0;
  logic [7:0] frm [0:255];
  logic [7:0] oData [0:255];
  logic oFirst [0:255];
  logic oLast [0:255];
  int oCnt = 0;

  always #4 clk = ~clk;

  udp_rx_filter u_dut (.*);

  always @(negedge clk) if (outValid && oCnt < 256) begin
    oData[oCnt] = outData; oFirst[oCnt] = outFirst; oLast[oCnt] = outLast;
    oCnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mkFrame(input logic [15:0] dport, input logic [15:0] ulen,
                         input int payBytes, input logic [7:0] seed);
    for (int i = 0; i < 256; i++) frm[i] = 8'h00;
    for (int k = 0; k < 6; k++) frm[k] = cfgMac[8*(5-k) +: 8];
    for (int k = 6; k < 12; k++) frm[k] = 8'hA0 + 8'(k);
    frm[12] = 8'h08; frm[13] = 8'h00; frm[14] = 8'h45; frm[22] = 8'h40;
    frm[20] = 8'h40; frm[21] = 8'h00; frm[23] = 8'd17;
    for (int k = 0; k < 4; k++) frm[26+k] = 8'h0A + 8'(k);
    for (int k = 0; k < 4; k++) frm[30+k] = cfgIp[8*(3-k) +: 8];
    frm[34] = 8'h30; frm[35] = 8'h39;
    frm[36] = dport[15:8]; frm[37] = dport[7:0];
    frm[38] = ulen[15:8];  frm[39] = ulen[7:0];
    for (int k = 0; k < payBytes && 42 + k < 256; k++) frm[42+k] = seed + 8'(k);
  endtask

  task automatic sendFrame(input int n, input bit withEof);
    oCnt = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      inValid = 1; inSof = (i == 0); inEof = withEof && (i == n - 1); inData = frm[i];
    end
    @(posedge clk); #1;
    inValid = 0; inSof = 0; inEof = 0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic checkOut(input string req, input int expN, input logic [7:0] seed);
    chk(oCnt == expN, {req, " byte count"}, oCnt, expN);
    for (int k = 0; k < expN && k < oCnt; k++) begin
      chk(oData[k] == seed + 8'(k), {req, " data"}, oData[k], seed + 8'(k));
      chk(oFirst[k] == (k == 0), {req, " first marker"}, oFirst[k], k == 0);
      chk(oLast[k] == (k == expN - 1), {req, " last marker"}, oLast[k], k == expN - 1);
    end
  endtask

  task automatic checkCounts(input string req);
    chk(acceptCount == 16'(expAcc), {req, " acceptCount"}, acceptCount, expAcc);
    chk(dropCount == 16'(expDrop), {req, " dropCount"}, dropCount, expDrop);
  endtask

  task automatic writeDrop(input logic [1:0] sel, input logic [15:0] port, input logic en);
    @(posedge clk); #1;
    dropWe = 1; dropSel = sel; dropPortIn = port; dropEnIn = en;
    @(posedge clk); #1;
    dropWe = 0;
  endtask

  // R1
  task automatic t_reset();
    chk(outValid == 0 && outFirst == 0 && outLast == 0, "R1 outputs idle", outValid, 0);
    checkCounts("R1 reset");
  endtask

  // R2 R5 R7: good frame with padding after the payload
  task automatic t_good();
    mkFrame(16'd5000, 16'd18, 10, 8'h10);
    sendFrame(64, 1);
    expAcc++;
    checkOut("R5 R7 good frame", 10, 8'h10);
    checkCounts("R2 accept");
  endtask

  // R3: one broken field at a time
  task automatic t_badFields();
    int offs [8] = '{0, 5, 12, 14, 20, 21, 23, 31};
    logic [7:0] vals [8] = '{8'h03, 8'h54, 8'h86, 8'h46, 8'h60, 8'h01, 8'd6, 8'hA9};
    for (int t = 0; t < 8; t++) begin
      mkFrame(16'd5000, 16'd20, 12, 8'h20);
      frm[offs[t]] = vals[t];
      sendFrame(60, 1);
      expDrop++;
      chk(oCnt == 0, "R3 bad field no output", oCnt, 0);
      checkCounts("R3 bad field");
    end
    mkFrame(16'd5001, 16'd20, 12, 8'h20);
    sendFrame(60, 1);
    expDrop++;
    chk(oCnt == 0, "R3 wrong port no output", oCnt, 0);
    checkCounts("R3 wrong port");
  endtask

  // R4
  task automatic t_dropTable();
    cfgPort = 16'd137;
    mkFrame(16'd137, 16'd12, 4, 8'h30);
    sendFrame(60, 1);
    expDrop++;
    chk(oCnt == 0, "R4 default entry 137", oCnt, 0);
    checkCounts("R4 default 137");
    cfgPort = 16'd5355;
    mkFrame(16'd5355, 16'd12, 4, 8'h30);
    sendFrame(60, 1);
    expDrop++;
    chk(oCnt == 0, "R4 default entry 5355", oCnt, 0);
    checkCounts("R4 default 5355");
    writeDrop(2'd1, 16'd5355, 1'b0);
    sendFrame(60, 1);
    expAcc++;
    checkOut("R4 disabled entry", 4, 8'h30);
    checkCounts("R4 disabled entry");
    cfgPort = 16'd5000;
    writeDrop(2'd2, 16'd5000, 1'b1);
    mkFrame(16'd5000, 16'd12, 4, 8'h30);
    sendFrame(60, 1);
    expDrop++;
    chk(oCnt == 0, "R4 written entry", oCnt, 0);
    checkCounts("R4 written entry");
    writeDrop(2'd2, 16'd5000, 1'b0);
  endtask

  // R6
  task automatic t_lengths();
    mkFrame(16'd5000, 16'd7, 0, 8'h00);
    sendFrame(60, 1);
    expDrop++;
    chk(oCnt == 0, "R6 length 7", oCnt, 0);
    checkCounts("R6 length 7");
    mkFrame(16'd5000, 16'd8, 0, 8'h00);
    sendFrame(60, 1);
    expAcc++;
    chk(oCnt == 0, "R6 length 8 no output", oCnt, 0);
    checkCounts("R6 length 8");
  endtask

  // R8
  task automatic t_early();
    mkFrame(16'd5000, 16'd20, 12, 8'h40);
    sendFrame(30, 1);
    expDrop++;
    chk(oCnt == 0, "R8 early end", oCnt, 0);
    checkCounts("R8 early end");
  endtask

  // R9: valid header image inside payload of a bad-MAC frame
  task automatic t_payloadImage();
    logic [7:0] img [0:41];
    mkFrame(16'd5000, 16'd100, 92, 8'h00);
    for (int k = 0; k < 42; k++) img[k] = frm[k];
    for (int k = 0; k < 42; k++) frm[42+k] = img[k];
    frm[0] = 8'hFF;
    sendFrame(134, 1);
    expDrop++;
    chk(oCnt == 0, "R9 image in payload", oCnt, 0);
    checkCounts("R9 image in payload");
  endtask

  // R10: unfinished frame then a fresh start-of-frame
  task automatic t_restart();
    mkFrame(16'd5000, 16'd20, 12, 8'h50);
    sendFrame(25, 0);
    sendFrame(60, 1);
    expAcc++;
    checkOut("R10 restart", 12, 8'h50);
    checkCounts("R10 restart");
  endtask

  // R11
  task automatic t_cutPayload();
    mkFrame(16'd5000, 16'd28, 20, 8'h60);
    sendFrame(47, 1);
    expAcc++;
    checkOut("R11 cut payload", 5, 8'h60);
    checkCounts("R11 cut payload");
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun + 1, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    t_reset();
    t_good();
    t_badFields();
    t_dropTable();
    t_lengths();
    t_early();
    t_payloadImage();
    t_restart();
    t_cutPayload();
    t_good();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule